// File: doc/BRIEF.md
# Dual-Mode External Bus Arbitration Controller

This block decides when an integrated controller may drive a shared external bus that another master also uses. A static mode input selects one of two arbitration schemes, and one state machine serves both of them. In requester mode the controller raises a bus request. It takes the bus only after it sees a grant together with a released acknowledge line, and then it drives the acknowledge line itself for as long as it holds the bus. In companion mode the controller is the default owner. It drives a grant to an attached processor while it has no use for the bus. It claims the bus with a busy line when it needs the bus and the processor is idle. If the processor then requests the bus with enough priority, the controller gives it up.

The internal need for the bus can be cancelled in two ways: by a halt indication that arrives without a refresh need, or by an external master that is accessing the on-chip dual-port memory. The external request, grant, acknowledge and halt pins are all active low, and each passes through a two-flop synchronizer before it reaches the state machine. Every output pin comes with its own drive enable. The bus cycles themselves are handled elsewhere.

Top module: `bus_arb_ctrl`

## Requirements
- R1: While reset is asserted the controller is idle. `owns_bus` is 0, `br_out_n` is 1, `bb_out_n` is 1 and `bgack_oe` is 0.
- R2: In requester mode (`mode_comp`=0), `br_oe` is 1 and `bg_oe`/`bb_oe` are 0. A bus need raised while idle drives `br_out_n` low after the next rising edge.
- R3: In requester mode the controller enters ownership only from the waiting state, and only when the synchronized `bg_in_n` is low and the synchronized `bgack_in_n` is high. On entry, `owns_bus` is 1, `bgack_out_n` is 0 and `br_out_n` returns to 1.
- R4: `bgack_oe` is 1 only in requester mode while `owns_bus` is 1. In every other case the acknowledge pin is tri-stated.
- R5: When `need_bus` falls while the controller owns the bus, the controller is idle after the next rising edge and stops driving its ownership pins.
- R6: A low `halt_n` cancels the bus need unless `refresh_need` is 1. Halt combined with refresh keeps the bus. Halt without refresh releases it and keeps it released.
- R7: While `ext_dpr_access` is 1, the controller is idle after the next rising edge and does not request or claim the bus.
- R8: A change on any external pin input takes effect on the state at the third rising edge after the change. Internal inputs take effect at the first.
- R9: In companion mode (`mode_comp`=1), while the controller is not owning the bus: `bg_out_n` is 0, `bg_oe` and `bb_oe` are 1, `bb_out_n` is 1, and `br_oe` is 0.
- R10: In companion mode, a need raised while `br_in_n` is high claims the bus after the next edge, with `bg_out_n`=1 and `bb_out_n`=0.
- R11: In companion mode, with the bus owned and `br_in_n` low, the controller yields after the next edge if `proc_prio` >= `own_prio` (unsigned). Otherwise it keeps the bus.
- R12: In companion mode the controller does not claim the bus while the synchronized `br_in_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_comp | input | 1 | Static mode: 0 requester, 1 companion |
| need_bus | input | 1 | Internal bus need |
| refresh_need | input | 1 | DRAM refresh needs the bus |
| ext_dpr_access | input | 1 | External master is accessing dual-port RAM |
| halt_n | input | 1 | Halt pin, active low |
| br_in_n | input | 1 | Processor bus request (companion), active low |
| bg_in_n | input | 1 | Bus grant from arbiter (requester), active low |
| bgack_in_n | input | 1 | Grant acknowledge seen on bus, active low |
| proc_prio | input | PRIO_W | Programmed processor request priority |
| own_prio | input | PRIO_W | Controller's own priority |
| br_out_n | output | 1 | Bus request pin value |
| br_oe | output | 1 | Bus request drive enable |
| bg_out_n | output | 1 | Grant pin value (companion) |
| bg_oe | output | 1 | Grant drive enable |
| bb_out_n | output | 1 | Bus-busy pin value (companion) |
| bb_oe | output | 1 | Bus-busy drive enable |
| bgack_out_n | output | 1 | Acknowledge pin value |
| bgack_oe | output | 1 | Acknowledge drive enable |
| owns_bus | output | 1 | Controller holds the external bus |

## Verification
On every cycle, the assertions check the following. Requester-mode ownership is entered only from the waiting state with the right grant and acknowledge levels. The acknowledge drive appears only with ownership. Grant and busy are never asserted together. Loss of need, a dual-port access and a high-enough processor priority each force idle on the next edge. While the processor requests, the controller never claims. Only the bench scenarios show the following: the exact three-edge synchronizer latency, the difference between halt with and without refresh, the equal-priority boundary of the compare, and the pin levels seen in each mode after reset.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;

  // bit positions in the synchronized pin vector
  localparam int PIN_ACK  = 0;
  localparam int PIN_BG   = 1;
  localparam int PIN_BR   = 2;
  localparam int PIN_HALT = 3;
  localparam int PIN_NUM  = 4;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import bus_arb_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_comp,
  input  logic              need_bus,
  input  logic              refresh_need,
  input  logic              ext_dpr_access,
  input  logic              halt_s,
  input  logic              ext_req_s,
  input  logic              grant_s,
  input  logic              ack_busy_s,
  input  logic [PRIO_W-1:0] proc_prio,
  input  logic [PRIO_W-1:0] own_prio,
  output arb_state_e        st
);
  arb_state_e st_nxt;
  logic       need_eff;
  logic       prio_ge;
  logic       st_en;

  assign need_eff = need_bus && !ext_dpr_access && !(halt_s && !refresh_need);
  assign prio_ge  = (proc_prio >= own_prio);
  assign st_en    = (st_nxt != st);

  always_comb begin
    st_nxt = st;
    unique case (st)
      ARB_IDLE: begin
        if (need_eff) begin
          if (!mode_comp)      st_nxt = ARB_WAIT;
          else if (!ext_req_s) st_nxt = ARB_OWN;
        end
      end
      ARB_WAIT: begin
        if (mode_comp || !need_eff)      st_nxt = ARB_IDLE;
        else if (grant_s && !ack_busy_s) st_nxt = ARB_OWN;
      end
      ARB_OWN: begin
        if (!need_eff)                                st_nxt = ARB_IDLE;
        else if (mode_comp && ext_req_s && prio_ge)   st_nxt = ARB_IDLE;
      end
      default: st_nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= ARB_IDLE;
    else if (st_en) st <= st_nxt;
  end

  // R3: requester-mode ownership is entered from the waiting state only
  a_r3_own_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_comp && st == ARB_OWN && $past(st) != ARB_OWN) |-> $past(st) == ARB_WAIT);
  // R3: entry follows grant seen with acknowledge released
  a_r3_grant_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_comp && st == ARB_OWN && $past(st) != ARB_OWN) |-> $past(grant_s && !ack_busy_s));
  // R5: losing the need releases the bus on the next edge
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARB_OWN && !need_bus) |=> st == ARB_IDLE);
  // R7: a dual-port access forces idle
  a_r7_dpr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dpr_access |=> st == ARB_IDLE);
  // R11: a high-enough processor request makes the controller yield
  a_r11_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_comp && st == ARB_OWN && ext_req_s && proc_prio >= own_prio) |=> st == ARB_IDLE);
  // R12: no claim while the processor requests
  a_r12_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_comp && st == ARB_IDLE && ext_req_s) |=> st == ARB_IDLE);
endmodule

// File: rtl/arb_pin_drv.sv
module arb_pin_drv
  import bus_arb_pkg::*;
(
  input  logic       mode_comp,
  input  arb_state_e st,
  output logic       br_out_n,
  output logic       br_oe,
  output logic       bg_out_n,
  output logic       bg_oe,
  output logic       bb_out_n,
  output logic       bb_oe,
  output logic       bgack_out_n,
  output logic       bgack_oe,
  output logic       owns_bus
);
  logic own_st;

  assign own_st = (st == ARB_OWN);

  always_comb begin
    owns_bus    = own_st;
    // requester-mode pins
    br_oe       = !mode_comp;
    br_out_n    = !(!mode_comp && st == ARB_WAIT);
    bgack_oe    = !mode_comp && own_st;
    bgack_out_n = !(!mode_comp && own_st);
    // companion-mode pins
    bg_oe       = mode_comp;
    bg_out_n    = !(mode_comp && !own_st);
    bb_oe       = mode_comp;
    bb_out_n    = !(mode_comp && own_st);
  end
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int PRIO_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_comp,
  input  logic              need_bus,
  input  logic              refresh_need,
  input  logic              ext_dpr_access,
  input  logic              halt_n,
  input  logic              br_in_n,
  input  logic              bg_in_n,
  input  logic              bgack_in_n,
  input  logic [PRIO_W-1:0] proc_prio,
  input  logic [PRIO_W-1:0] own_prio,
  output logic              br_out_n,
  output logic              br_oe,
  output logic              bg_out_n,
  output logic              bg_oe,
  output logic              bb_out_n,
  output logic              bb_oe,
  output logic              bgack_out_n,
  output logic              bgack_oe,
  output logic              owns_bus
);
  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic [PIN_NUM-1:0] pins_raw;
  logic [PIN_NUM-1:0] pins_s;
  arb_state_e         st;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    pins_raw           = '1;
    pins_raw[PIN_ACK]  = bgack_in_n;
    pins_raw[PIN_BG]   = bg_in_n;
    pins_raw[PIN_BR]   = br_in_n;
    pins_raw[PIN_HALT] = halt_n;
  end

  arb_sync #(.W(PIN_NUM), .STAGES(SYNC_STAGES), .RST_VAL({PIN_NUM{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  arb_fsm #(.PRIO_W(PRIO_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .mode_comp      (mode_comp),
    .need_bus       (need_bus),
    .refresh_need   (refresh_need),
    .ext_dpr_access (ext_dpr_access),
    .halt_s         (!pins_s[PIN_HALT]),
    .ext_req_s      (!pins_s[PIN_BR]),
    .grant_s        (!pins_s[PIN_BG]),
    .ack_busy_s     (!pins_s[PIN_ACK]),
    .proc_prio      (proc_prio),
    .own_prio       (own_prio),
    .st             (st)
  );

  arb_pin_drv u_drv (
    .mode_comp   (mode_comp),
    .st          (st),
    .br_out_n    (br_out_n),
    .br_oe       (br_oe),
    .bg_out_n    (bg_out_n),
    .bg_oe       (bg_oe),
    .bb_out_n    (bb_out_n),
    .bb_oe       (bb_oe),
    .bgack_out_n (bgack_out_n),
    .bgack_oe    (bgack_oe),
    .owns_bus    (owns_bus)
  );

  // R4: acknowledge is driven only by the owner
  a_r4_ack_only_owner: assert property (@(posedge clk) disable iff (!rst_int_n)
    bgack_oe |-> (owns_bus && !bgack_out_n));
  // R3: the request is withdrawn once the bus is held
  a_r3_br_neg_own: assert property (@(posedge clk) disable iff (!rst_int_n)
    owns_bus |-> br_out_n);
  // R10: grant and busy never asserted together in companion mode
  a_r10_bg_bb_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bg_oe && bb_oe) |-> (bg_out_n != bb_out_n));
endmodule

// File: tb/bus_arb_ctrl_tb.sv
module bus_arb_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_comp, need_bus, refresh_need, ext_dpr_access;
  logic       halt_n, br_in_n, bg_in_n, bgack_in_n;
  logic [2:0] proc_prio, own_prio;
  logic       br_out_n, br_oe, bg_out_n, bg_oe, bb_out_n, bb_oe;
  logic       bgack_out_n, bgack_oe, owns_bus;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bus_arb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_comp(mode_comp), .need_bus(need_bus),
    .refresh_need(refresh_need), .ext_dpr_access(ext_dpr_access),
    .halt_n(halt_n), .br_in_n(br_in_n), .bg_in_n(bg_in_n), .bgack_in_n(bgack_in_n),
    .proc_prio(proc_prio), .own_prio(own_prio),
    .br_out_n(br_out_n), .br_oe(br_oe), .bg_out_n(bg_out_n), .bg_oe(bg_oe),
    .bb_out_n(bb_out_n), .bb_oe(bb_oe), .bgack_out_n(bgack_out_n),
    .bgack_oe(bgack_oe), .owns_bus(owns_bus)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; mode_comp = mode; need_bus = 0; refresh_need = 0;
    ext_dpr_access = 0; halt_n = 1; br_in_n = 1; bg_in_n = 1; bgack_in_n = 1;
    proc_prio = 3'd0; own_prio = 3'd4;
    step(3);
    chk("R1 owns_bus", owns_bus, 1'b0);
    chk("R1 br_out_n", br_out_n, 1'b1);
    chk("R1 bb_out_n", bb_out_n, mode ? 1'b1 : 1'b1);
    chk("R1 bgack_oe", bgack_oe, 1'b0);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_slave_grant;
    need_bus = 1;
    step(1);
    chk("R2 br_out_n asserted", br_out_n, 1'b0);
    chk("R2 br_oe", br_oe, 1'b1);
    chk("R2 bg_oe", bg_oe, 1'b0);
    chk("R2 bb_oe", bb_oe, 1'b0);
    bg_in_n = 0;
    step(2);
    chk("R8 not yet owning", owns_bus, 1'b0);
    step(1);
    chk("R3 owns_bus", owns_bus, 1'b1);
    chk("R3 bgack_out_n", bgack_out_n, 1'b0);
    chk("R3 br_out_n negated", br_out_n, 1'b1);
    chk("R4 bgack_oe owner", bgack_oe, 1'b1);
    need_bus = 0;
    step(1);
    chk("R5 released", owns_bus, 1'b0);
    chk("R4 bgack tri-stated", bgack_oe, 1'b0);
    bg_in_n = 1;
    step(4);
  endtask

  task automatic t_slave_ack_busy;
    bg_in_n = 0; bgack_in_n = 0; need_bus = 1;
    step(8);
    chk("R3 held off by ack", owns_bus, 1'b0);
    chk("R3 still requesting", br_out_n, 1'b0);
    bgack_in_n = 1;
    step(4);
    chk("R3 owns after ack release", owns_bus, 1'b1);
    need_bus = 0; bg_in_n = 1;
    step(4);
  endtask

  task automatic t_halt;
    need_bus = 1; bg_in_n = 0;
    step(5);
    chk("R6 owns before halt", owns_bus, 1'b1);
    refresh_need = 1; halt_n = 0;
    step(5);
    chk("R6 halt with refresh keeps", owns_bus, 1'b1);
    refresh_need = 0;
    step(1);
    chk("R6 halt releases", owns_bus, 1'b0);
    step(4);
    chk("R6 stays released", owns_bus, 1'b0);
    chk("R6 no request", br_out_n, 1'b1);
    need_bus = 0; halt_n = 1; bg_in_n = 1;
    step(4);
  endtask

  task automatic t_dpr;
    need_bus = 1; bg_in_n = 0;
    step(5);
    chk("R7 owns before access", owns_bus, 1'b1);
    ext_dpr_access = 1;
    step(1);
    chk("R7 leaves bus", owns_bus, 1'b0);
    step(5);
    chk("R7 stays idle", owns_bus, 1'b0);
    chk("R7 no request", br_out_n, 1'b1);
    ext_dpr_access = 0;
    step(4);
    chk("R7 retakes after access", owns_bus, 1'b1);
    need_bus = 0; bg_in_n = 1;
    step(4);
  endtask

  task automatic t_comp_claim_prio;
    chk("R9 bg_out_n asserted", bg_out_n, 1'b0);
    chk("R9 bg_oe", bg_oe, 1'b1);
    chk("R9 bb_oe", bb_oe, 1'b1);
    chk("R9 bb_out_n negated", bb_out_n, 1'b1);
    chk("R9 br_oe", br_oe, 1'b0);
    need_bus = 1;
    step(1);
    chk("R10 owns", owns_bus, 1'b1);
    chk("R10 bg_out_n negated", bg_out_n, 1'b1);
    chk("R10 bb_out_n asserted", bb_out_n, 1'b0);
    chk("R4 no ack in companion", bgack_oe, 1'b0);
    proc_prio = 3'd2; own_prio = 3'd5; br_in_n = 0;
    step(6);
    chk("R11 low prio holds", owns_bus, 1'b1);
    proc_prio = 3'd5;
    step(1);
    chk("R11 equal prio yields", owns_bus, 1'b0);
    chk("R11 grant back", bg_out_n, 1'b0);
    chk("R11 busy negated", bb_out_n, 1'b1);
    step(5);
    chk("R12 no claim while requested", owns_bus, 1'b0);
    br_in_n = 1;
    step(2);
    chk("R8 request still seen", owns_bus, 1'b0);
    step(1);
    chk("R12 reclaims", owns_bus, 1'b1);
    need_bus = 0;
    step(1);
    chk("R5 companion release", owns_bus, 1'b0);
    chk("R9 grant after release", bg_out_n, 1'b0);
  endtask

  initial begin
    do_reset(1'b0);
    t_slave_grant();
    t_slave_ack_busy();
    t_halt();
    t_dpr();
    do_reset(1'b1);
    t_comp_claim_prio();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule